// File: doc/BRIEF.md
# Decoded Micro-Op Cache

This block keeps micro-ops that a decoder has already produced, so that a front end which revisits the same code can skip decoding. Micro-ops are fixed-width tokens that the cache never interprets. A microcoded instruction is held as one such token, which points into microcode storage, so it costs a single slot. Entries are found by the virtual address of a 32-byte fetch window. No translation is needed before the index is taken or the tag is compared.

A fill port takes the micro-ops of one window, from 1 to 18 of them, and packs them six to a line into up to three lines of one way of the indexed set. There are 32 sets of 8 ways. A lookup port takes a window address and answers hit or miss one cycle later. On a hit, a copy of the window is streamed out, up to four micro-ops per cycle, until it is used up. A window is only reported as a hit when every one of its lines is present. A flush input empties the whole cache in one cycle.

Top module: `uop_cache`

## Requirements
- R1: After reset, `lk_ready` is 1, `uop_valid` and `lk_resp` are 0, and every lookup misses.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both 1. `lk_resp` is 1 in the next cycle, and only then. `lk_hit` is 1 in that cycle exactly when the window is cached. The set is `lk_addr[9:5]`, the tag is `lk_addr[31:10]`, and `lk_addr[4:0]` has no effect.
- R3: On a hit, the first beat appears in the same cycle as `lk_hit`. Each beat carries micro-ops in fill order, with the oldest in `uop_data[15:0]`. Every beat before the last carries 4 micro-ops. The last beat carries the remainder and raises `uop_last`. Slots beyond `uop_count` are zero.
- R4: `lk_ready` is 0 from the first beat through the last beat. A lookup presented while `lk_ready` is 0 gets no response.
- R5: A fill with `fill_count` from 1 to 18 is stored, with micro-op i taken from `fill_uops[16*i +: 16]`. A fill with count 0 or more than 18 is dropped, and a later lookup of that window misses.
- R6: A fill of a window that is already cached replaces it, and later hits return the new micro-ops.
- R7: A fill takes an empty way of the set if there is one. Otherwise it takes the least recently used way, where hits and fills both count as use. Replacing a way makes the window that was there miss.
- R8: A flush empties the cache at the next edge. A lookup in the flush cycle responds with a miss. A fill in the flush cycle is dropped. A stream in progress ends, with `uop_valid` 0 in the next cycle.
- R9: A lookup and a fill of the same window in the same cycle: the lookup sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every entry |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | 32 | Window virtual address of the fill |
| fill_count | input | 6 | Number of micro-ops in the fill |
| fill_uops | input | 288 | Micro-op tokens, slot i at bits 16*i |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Window virtual address to look up |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_resp | output | 1 | Lookup answer is present |
| lk_hit | output | 1 | Answer is a hit |
| uop_valid | output | 1 | A beat is on `uop_data` |
| uop_count | output | 3 | Micro-ops in this beat (1 to 4) |
| uop_data | output | 64 | Beat micro-ops, oldest in the low 16 bits |
| uop_last | output | 1 | Final beat of the window |

## Verification
A table of windows is filled into distinct sets with counts of 1, 4, 5, 6, 7, 12, 13 and 18. These counts tell apart a single partial line, an exactly full line, two lines and three lines, and the final-beat remainders 1 to 4. Each window is looked up with its own offset bits, with different offset bits, and with a changed tag in the same set, which separates index, tag and ignored bits. Directed sequences then fill one set past its eight ways around a refreshing hit to expose the replacement order. Further sequences cover oversized and empty fills, replacement of a cached window, lookups while a stream is running, a flush landing mid-stream or alongside a lookup or fill, and a fill that collides with a lookup.

// File: rtl/uopc_pkg.sv
package uopc_pkg;

    localparam int unsigned DEF_VA_W      = 32;
    localparam int unsigned DEF_SETS      = 32;
    localparam int unsigned DEF_WAYS      = 8;
    localparam int unsigned DEF_LINE_UOPS = 6;
    localparam int unsigned DEF_MAX_LINES = 3;
    localparam int unsigned DEF_BEAT      = 4;
    localparam int unsigned DEF_UOP_W     = 16;
    localparam int unsigned DEF_WIN_BYTES = 32;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } strm_state_e;

endpackage

// File: rtl/uopc_match.sv
module uopc_match #(
    parameter int unsigned WAYS      = 8,
    parameter int unsigned MAX_LINES = 3,
    parameter int unsigned TAG_W     = 22,
    parameter int unsigned LCNT_W    = 3,
    parameter int unsigned SEQ_W     = 2,
    parameter int unsigned CNT_W     = 5,
    localparam int unsigned WAY_W    = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][MAX_LINES-1:0]             vld,
    input  logic [WAYS-1:0][MAX_LINES-1:0][TAG_W-1:0]  tag,
    input  logic [WAYS-1:0][MAX_LINES-1:0][LCNT_W-1:0] cnt,
    input  logic [WAYS-1:0][MAX_LINES-1:0][SEQ_W-1:0]  seq,
    input  logic [WAYS-1:0][MAX_LINES-1:0]             last,
    input  logic [TAG_W-1:0]                           key,
    output logic                                       hit,
    output logic [WAY_W-1:0]                           hit_way,
    output logic [CNT_W-1:0]                           total
);

    // A way hits only when an unbroken chain of lines 0,1,.. with the
    // right tag and sequence numbers ends in a line marked last.
    logic             ok, prev_ok, prev_last, whit;
    logic [CNT_W-1:0] tot;

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        total   = '0;
        ok        = 1'b0;
        prev_ok   = 1'b1;
        prev_last = 1'b0;
        whit      = 1'b0;
        tot       = '0;
        for (int w = 0; w < WAYS; w++) begin
            prev_ok   = 1'b1;
            prev_last = 1'b0;
            whit      = 1'b0;
            tot       = '0;
            for (int j = 0; j < MAX_LINES; j++) begin
                ok = vld[w][j] && (tag[w][j] == key) &&
                     (seq[w][j] == SEQ_W'(j)) && prev_ok && !prev_last;
                if (ok) tot = tot + CNT_W'(cnt[w][j]);
                if (ok && last[w][j]) whit = 1'b1;
                prev_ok   = ok;
                prev_last = last[w][j];
            end
            if (whit && !hit) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
                total   = tot;
            end
        end
    end

endmodule

// File: rtl/uopc_lru.sv
module uopc_lru #(
    parameter int unsigned SETS = 32,
    parameter int unsigned WAYS = 8,
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             t0_en,
    input  logic [SET_W-1:0] t0_set,
    input  logic [WAY_W-1:0] t0_way,
    input  logic             t1_en,
    input  logic [SET_W-1:0] t1_set,
    input  logic [WAY_W-1:0] t1_way,
    input  logic [SET_W-1:0] v_set,
    input  logic [WAYS-1:0]  v_occ,
    output logic [WAY_W-1:0] victim
);

    typedef logic [WAYS-1:0][WAY_W-1:0] row_t;

    // Age 0 is most recent, WAYS-1 least recent; a row is always a permutation.
    row_t age_q [SETS];

    function automatic row_t touch(row_t r, logic [WAY_W-1:0] w);
        row_t n = r;
        for (int k = 0; k < WAYS; k++)
            if (r[k] < r[w]) n[k] = r[k] + WAY_W'(1);
        n[w] = '0;
        return n;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int k = 0; k < WAYS; k++)
                    age_q[s][k] <= WAY_W'(k);
        end else begin
            if (t0_en)
                age_q[t0_set] <= touch(age_q[t0_set], t0_way);
            if (t1_en)
                age_q[t1_set] <= touch((t0_en && t0_set == t1_set) ?
                                       touch(age_q[t1_set], t0_way) :
                                       age_q[t1_set], t1_way);
        end
    end

    logic found;
    always_comb begin
        found  = 1'b0;
        victim = '0;
        for (int k = WAYS - 1; k >= 0; k--) begin
            if (!v_occ[k]) begin
                victim = WAY_W'(k);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int k = 0; k < WAYS; k++)
                if (age_q[v_set][k] == WAY_W'(WAYS - 1)) victim = WAY_W'(k);
        end
    end

endmodule

// File: rtl/uopc_stream.sv
module uopc_stream
    import uopc_pkg::*;
#(
    parameter int unsigned UOP_W    = 16,
    parameter int unsigned WIN_UOPS = 18,
    parameter int unsigned BEAT     = 4,
    localparam int unsigned CNT_W   = $clog2(WIN_UOPS + 1),
    localparam int unsigned BEAT_CW = $clog2(BEAT + 1)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               abort,
    input  logic                               load,
    input  logic [WIN_UOPS-1:0][UOP_W-1:0]     load_uops,
    input  logic [CNT_W-1:0]                   load_total,
    output logic                               busy,
    output logic                               out_valid,
    output logic [BEAT_CW-1:0]                 out_cnt,
    output logic [BEAT-1:0][UOP_W-1:0]         out_data,
    output logic                               out_last
);

    strm_state_e                 state_q;
    logic [CNT_W-1:0]            ptr_q, total_q, rem;
    logic [WIN_UOPS-1:0][UOP_W-1:0] buf_q;

    assign rem       = total_q - ptr_q;
    assign out_valid = (state_q == ST_STREAM);
    assign busy      = out_valid;
    assign out_last  = out_valid && (rem <= CNT_W'(BEAT));
    assign out_cnt   = !out_valid ? '0 :
                       (rem >= CNT_W'(BEAT)) ? BEAT_CW'(BEAT) : BEAT_CW'(rem);

    always_comb begin
        for (int k = 0; k < BEAT; k++) begin
            out_data[k] = '0;
            if (out_valid && (k < int'(out_cnt)) && (int'(ptr_q) + k < WIN_UOPS))
                out_data[k] = buf_q[int'(ptr_q) + k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            total_q <= '0;
            buf_q   <= '0;
        end else if (abort) begin
            state_q <= ST_IDLE;
        end else if (load) begin
            state_q <= ST_STREAM;
            ptr_q   <= '0;
            total_q <= load_total;
            buf_q   <= load_uops;
        end else if (state_q == ST_STREAM) begin
            if (rem <= CNT_W'(BEAT)) state_q <= ST_IDLE;
            else                     ptr_q   <= ptr_q + CNT_W'(BEAT);
        end
    end

endmodule

// File: rtl/uop_cache.sv
module uop_cache
    import uopc_pkg::*;
#(
    parameter int unsigned VA_W      = DEF_VA_W,
    parameter int unsigned SETS      = DEF_SETS,
    parameter int unsigned WAYS      = DEF_WAYS,
    parameter int unsigned LINE_UOPS = DEF_LINE_UOPS,
    parameter int unsigned MAX_LINES = DEF_MAX_LINES,
    parameter int unsigned BEAT      = DEF_BEAT,
    parameter int unsigned UOP_W     = DEF_UOP_W,
    parameter int unsigned WIN_BYTES = DEF_WIN_BYTES,
    localparam int unsigned WIN_UOPS = LINE_UOPS * MAX_LINES,
    localparam int unsigned CNT_W    = $clog2(WIN_UOPS + 1),
    localparam int unsigned FCNT_W   = CNT_W + 1,
    localparam int unsigned BEAT_CW  = $clog2(BEAT + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      fill_valid,
    input  logic [VA_W-1:0]           fill_addr,
    input  logic [FCNT_W-1:0]         fill_count,
    input  logic [WIN_UOPS*UOP_W-1:0] fill_uops,
    input  logic                      lk_valid,
    input  logic [VA_W-1:0]           lk_addr,
    output logic                      lk_ready,
    output logic                      lk_resp,
    output logic                      lk_hit,
    output logic                      uop_valid,
    output logic [BEAT_CW-1:0]        uop_count,
    output logic [BEAT*UOP_W-1:0]     uop_data,
    output logic                      uop_last
);

    localparam int unsigned SET_W     = $clog2(SETS);
    localparam int unsigned WAY_W     = $clog2(WAYS);
    localparam int unsigned OFS_W     = $clog2(WIN_BYTES);
    localparam int unsigned TAG_W     = VA_W - SET_W - OFS_W;
    localparam int unsigned LCNT_W    = $clog2(LINE_UOPS + 1);
    localparam int unsigned SEQ_W     = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;
    localparam int unsigned LINE_BITS = LINE_UOPS * UOP_W;
    localparam int unsigned NPORT     = 2;   // 0: lookup, 1: fill

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [LCNT_W-1:0] cnt;
        logic [SEQ_W-1:0]  seq;
        logic              last;
    } meta_t;

    // ---------------- storage ----------------
    logic [MAX_LINES-1:0] vld_q  [SETS][WAYS];
    meta_t                meta_q [SETS][WAYS][MAX_LINES];
    logic [LINE_BITS-1:0] data_q [SETS][WAYS][MAX_LINES];

    // ---------------- address split ----------------
    logic [NPORT-1:0][SET_W-1:0] pset;
    logic [NPORT-1:0][TAG_W-1:0] ptag;
    assign pset[0] = lk_addr[OFS_W +: SET_W];
    assign ptag[0] = lk_addr[VA_W-1 -: TAG_W];
    assign pset[1] = fill_addr[OFS_W +: SET_W];
    assign ptag[1] = fill_addr[VA_W-1 -: TAG_W];

    // ---------------- tag match, one per port ----------------
    logic [NPORT-1:0][WAYS-1:0][MAX_LINES-1:0]             m_vld;
    logic [NPORT-1:0][WAYS-1:0][MAX_LINES-1:0][TAG_W-1:0]  m_tag;
    logic [NPORT-1:0][WAYS-1:0][MAX_LINES-1:0][LCNT_W-1:0] m_cnt;
    logic [NPORT-1:0][WAYS-1:0][MAX_LINES-1:0][SEQ_W-1:0]  m_seq;
    logic [NPORT-1:0][WAYS-1:0][MAX_LINES-1:0]             m_last;
    logic [NPORT-1:0]                                      m_hit;
    logic [NPORT-1:0][WAY_W-1:0]                           m_way;
    logic [NPORT-1:0][CNT_W-1:0]                           m_total;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            for (genvar j = 0; j < MAX_LINES; j++) begin : g_line
                assign m_vld[p][w][j]  = vld_q[pset[p]][w][j];
                assign m_tag[p][w][j]  = meta_q[pset[p]][w][j].tag;
                assign m_cnt[p][w][j]  = meta_q[pset[p]][w][j].cnt;
                assign m_seq[p][w][j]  = meta_q[pset[p]][w][j].seq;
                assign m_last[p][w][j] = meta_q[pset[p]][w][j].last;
            end
        end
        uopc_match #(
            .WAYS(WAYS), .MAX_LINES(MAX_LINES), .TAG_W(TAG_W),
            .LCNT_W(LCNT_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
        ) u_match (
            .vld(m_vld[p]), .tag(m_tag[p]), .cnt(m_cnt[p]), .seq(m_seq[p]),
            .last(m_last[p]), .key(ptag[p]),
            .hit(m_hit[p]), .hit_way(m_way[p]), .total(m_total[p])
        );
    end

    // ---------------- control ----------------
    logic busy, lk_acc, hit_now, fill_acc;
    logic [WAY_W-1:0] lru_victim, fill_way;
    logic [WAYS-1:0]  occ;

    assign lk_ready = !busy;
    assign lk_acc   = lk_valid && !busy;
    assign hit_now  = lk_acc && m_hit[0] && !flush;
    assign fill_acc = fill_valid && !flush && (fill_count != '0) &&
                      (fill_count <= FCNT_W'(WIN_UOPS));

    for (genvar w = 0; w < WAYS; w++) begin : g_occ
        assign occ[w] = vld_q[pset[1]][w][0];
    end

    uopc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst(rst),
        .t0_en(hit_now), .t0_set(pset[0]), .t0_way(m_way[0]),
        .t1_en(fill_acc), .t1_set(pset[1]), .t1_way(fill_way),
        .v_set(pset[1]), .v_occ(occ), .victim(lru_victim)
    );

    // A window already present is rewritten in place.
    assign fill_way = m_hit[1] ? m_way[1] : lru_victim;

    // ---------------- fill line images ----------------
    meta_t                fl_meta [MAX_LINES];
    logic [LINE_BITS-1:0] fl_data [MAX_LINES];
    logic [MAX_LINES-1:0] fl_use;

    for (genvar j = 0; j < MAX_LINES; j++) begin : g_fill
        localparam int unsigned BASE = j * LINE_UOPS;
        assign fl_use[j]       = fill_count > FCNT_W'(BASE);
        assign fl_meta[j].tag  = ptag[1];
        assign fl_meta[j].cnt  = (fill_count >= FCNT_W'(BASE + LINE_UOPS)) ?
                                 LCNT_W'(LINE_UOPS) :
                                 LCNT_W'(fill_count - FCNT_W'(BASE));
        assign fl_meta[j].seq  = SEQ_W'(j);
        assign fl_meta[j].last = fill_count <= FCNT_W'(BASE + LINE_UOPS);
        assign fl_data[j]      = fill_uops[j*LINE_BITS +: LINE_BITS];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    vld_q[s][w] <= '0;
        end else if (fill_acc) begin
            vld_q[pset[1]][fill_way] <= fl_use;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_acc) begin
            for (int j = 0; j < MAX_LINES; j++) begin
                meta_q[pset[1]][fill_way][j] <= fl_meta[j];
                data_q[pset[1]][fill_way][j] <= fl_data[j];
            end
        end
    end

    // ---------------- lookup answer and streaming ----------------
    logic [WIN_UOPS-1:0][UOP_W-1:0] win_uops;
    for (genvar j = 0; j < MAX_LINES; j++) begin : g_gl
        for (genvar k = 0; k < LINE_UOPS; k++) begin : g_gs
            assign win_uops[j*LINE_UOPS + k] = data_q[pset[0]][m_way[0]][j][k*UOP_W +: UOP_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_resp <= 1'b0;
            lk_hit  <= 1'b0;
        end else begin
            lk_resp <= lk_acc;
            lk_hit  <= hit_now;
        end
    end

    logic [BEAT-1:0][UOP_W-1:0] beat_data;

    uopc_stream #(.UOP_W(UOP_W), .WIN_UOPS(WIN_UOPS), .BEAT(BEAT)) u_stream (
        .clk(clk), .rst(rst), .abort(flush), .load(hit_now),
        .load_uops(win_uops), .load_total(m_total[0]),
        .busy(busy), .out_valid(uop_valid), .out_cnt(uop_count),
        .out_data(beat_data), .out_last(uop_last)
    );

    assign uop_data = beat_data;

endmodule

// File: rtl/uopc_checker.sv
module uopc_checker #(
    parameter int unsigned BEAT = 4,
    localparam int unsigned BEAT_CW = $clog2(BEAT + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               lk_valid,
    input logic               lk_ready,
    input logic               lk_resp,
    input logic               lk_hit,
    input logic               uop_valid,
    input logic [BEAT_CW-1:0] uop_count,
    input logic               uop_last
);

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> lk_resp);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(lk_valid && lk_ready) |=> !lk_resp);

    a_r2_hit_in_resp: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_resp);

    a_r3_first_beat: assert property (@(posedge clk) disable iff (rst)
        (lk_resp && lk_hit) |-> uop_valid);

    a_r3_last_valid: assert property (@(posedge clk) disable iff (rst)
        uop_last |-> uop_valid);

    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> (uop_count >= BEAT_CW'(1) && uop_count <= BEAT_CW'(BEAT)));

    a_r3_full_beat: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_last) |-> (uop_count == BEAT_CW'(BEAT)));

    a_r3_continue: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_last && !flush) |=> uop_valid);

    a_r4_not_ready: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> !lk_ready);

    a_r4_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        (lk_resp && !lk_hit) |-> !uop_valid);

    a_r8_flush_stop: assert property (@(posedge clk) disable iff (rst)
        flush |=> !uop_valid);

endmodule

bind uop_cache uopc_checker #(.BEAT(BEAT)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_resp(lk_resp), .lk_hit(lk_hit),
    .uop_valid(uop_valid), .uop_count(uop_count), .uop_last(uop_last)
);

// File: tb/tb_uop_cache.sv
`timescale 1ns/1ps
module tb_uop_cache;

    localparam int NV = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         flush = 1'b0;
    logic         fill_valid = 1'b0;
    logic [31:0]  fill_addr = '0;
    logic [5:0]   fill_count = '0;
    logic [287:0] fill_uops = '0;
    logic         lk_valid = 1'b0;
    logic [31:0]  lk_addr = '0;
    logic         lk_ready, lk_resp, lk_hit, uop_valid, uop_last;
    logic [2:0]   uop_count;
    logic [63:0]  uop_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    uop_cache dut (
        .clk(clk), .rst(rst), .flush(flush),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_count(fill_count), .fill_uops(fill_uops),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
        .lk_resp(lk_resp), .lk_hit(lk_hit), .uop_valid(uop_valid),
        .uop_count(uop_count), .uop_data(uop_data), .uop_last(uop_last)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [5:0]  cnt;
        logic [7:0]  seed;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'h0000_0400, 6'd1,  8'h11},
        '{32'h0000_0823, 6'd4,  8'h22},
        '{32'h0000_0C5F, 6'd5,  8'h33},
        '{32'h1234_5460, 6'd6,  8'h44},
        '{32'h0000_1080, 6'd7,  8'h55},
        '{32'h0000_14A0, 6'd12, 8'h66},
        '{32'h0000_18C0, 6'd13, 8'h77},
        '{32'hFFFF_FFE0, 6'd18, 8'h88}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [287:0] mk_uops(input logic [7:0] seed, input int cnt);
        logic [287:0] r = '0;
        for (int i = 0; i < 18; i++)
            if (i < cnt) r[i*16 +: 16] = {seed, 8'(i)};
        return r;
    endfunction

    function automatic logic [63:0] exp_beat(input logic [7:0] seed, input int cnt,
                                             input int b);
        logic [63:0] r = '0;
        for (int k = 0; k < 4; k++)
            if (b*4 + k < cnt) r[k*16 +: 16] = {seed, 8'(b*4 + k)};
        return r;
    endfunction

    task automatic do_fill(input logic [31:0] a, input int cnt, input logic [7:0] seed);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_count = 6'(cnt);
        fill_uops  = mk_uops(seed, cnt);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Checks the answer and, on a hit, every beat of the stream.
    task automatic do_lookup(input logic [31:0] a, input bit exp_hit,
                             input logic [7:0] seed, input int cnt, input string req);
        int nb;
        @(negedge clk);
        chk(lk_ready == 1'b1, {req, " ready before lookup"}, 64'(lk_ready), 64'd1);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(lk_resp == 1'b1, {req, " response"}, 64'(lk_resp), 64'd1);
        chk(lk_hit == exp_hit, {req, " hit"}, 64'(lk_hit), 64'(exp_hit));
        if (exp_hit) begin
            nb = (cnt + 3) / 4;
            for (int b = 0; b < nb; b++) begin
                chk(uop_valid == 1'b1, {req, " beat valid"}, 64'(uop_valid), 64'd1);
                chk(int'(uop_count) == ((cnt - 4*b) > 4 ? 4 : cnt - 4*b),
                    {req, " beat count"}, 64'(uop_count),
                    64'((cnt - 4*b) > 4 ? 4 : cnt - 4*b));
                chk(uop_data == exp_beat(seed, cnt, b), {req, " beat data"},
                    uop_data, exp_beat(seed, cnt, b));
                chk(uop_last == (b == nb - 1), {req, " beat last"},
                    64'(uop_last), 64'(b == nb - 1));
                @(negedge clk);
            end
            chk(uop_valid == 1'b0 && lk_ready == 1'b1, "R4 ready after stream",
                64'({uop_valid, lk_ready}), 64'b01);
        end else begin
            chk(uop_valid == 1'b0, {req, " no beat on miss"}, 64'(uop_valid), 64'd0);
        end
    endtask

    function automatic logic [31:0] set7(input int t);
        return (32'(t) << 10) | (32'd7 << 5);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(lk_ready == 1'b1, "R1 lk_ready in reset", 64'(lk_ready), 64'd1);
        chk(uop_valid == 1'b0, "R1 uop_valid in reset", 64'(uop_valid), 64'd0);
        chk(lk_resp == 1'b0, "R1 lk_resp in reset", 64'(lk_resp), 64'd0);
        rst = 1'b0;
        do_lookup(VECS[0].addr, 1'b0, 8'h0, 0, "R1");

        // Table: fill every window, then look each up three ways.
        for (int i = 0; i < NV; i++)
            do_fill(VECS[i].addr, int'(VECS[i].cnt), VECS[i].seed);
        for (int i = 0; i < NV; i++) begin
            do_lookup(VECS[i].addr, 1'b1, VECS[i].seed, int'(VECS[i].cnt), "R3");
            do_lookup({VECS[i].addr[31:5], 5'(i*4 + 1)}, 1'b1, VECS[i].seed,
                      int'(VECS[i].cnt), "R2 offset ignored");
            do_lookup(VECS[i].addr ^ 32'h8000_0000, 1'b0, 8'h0, 0, "R2 tag differs");
        end

        // R5: empty and oversized fills are dropped
        do_fill(32'h0000_0100, 0, 8'h90);
        do_lookup(32'h0000_0100, 1'b0, 8'h0, 0, "R5 count 0");
        do_fill(32'h0000_0120, 19, 8'h91);
        do_lookup(32'h0000_0120, 1'b0, 8'h0, 0, "R5 count 19");

        // R6: refill replaces the cached window
        do_fill(VECS[2].addr, 9, 8'hAB);
        do_lookup(VECS[2].addr, 1'b1, 8'hAB, 9, "R6 replaced");

        // R7: empty ways first, then least recently used
        for (int t = 1; t <= 8; t++) do_fill(set7(t), 2, 8'(8'h70 + t));
        for (int t = 1; t <= 8; t++) do_lookup(set7(t), 1'b1, 8'(8'h70 + t), 2, "R7 all ways");
        do_lookup(set7(1), 1'b1, 8'h71, 2, "R7 refresh");
        do_fill(set7(9), 2, 8'h79);
        do_lookup(set7(2), 1'b0, 8'h0, 0, "R7 lru evicted");
        do_lookup(set7(1), 1'b1, 8'h71, 2, "R7 refreshed kept");
        do_lookup(set7(9), 1'b1, 8'h79, 2, "R7 new window");

        // R4: lookup during a stream is ignored
        do_fill(32'h0000_2100, 18, 8'hC1);
        do_fill(32'h0000_2120, 2, 8'hC2);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'h0000_2100;
        @(negedge clk);
        lk_addr = 32'h0000_2120;
        chk(lk_ready == 1'b0, "R4 busy during stream", 64'(lk_ready), 64'd0);
        @(negedge clk);
        lk_valid = 1'b0;
        chk(lk_resp == 1'b0, "R4 ignored lookup", 64'(lk_resp), 64'd0);
        chk(uop_data == exp_beat(8'hC1, 18, 1), "R4 stream undisturbed",
            uop_data, exp_beat(8'hC1, 18, 1));
        for (int n = 0; n < 10 && uop_valid; n++) @(negedge clk);
        do_lookup(32'h0000_2120, 1'b1, 8'hC2, 2, "R4 after stream");

        // R8: flush mid-stream
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'h0000_2100;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(uop_valid == 1'b1, "R8 stream started", 64'(uop_valid), 64'd1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(uop_valid == 1'b0, "R8 stream cut", 64'(uop_valid), 64'd0);
        chk(lk_ready == 1'b1, "R8 ready after flush", 64'(lk_ready), 64'd1);
        do_lookup(32'h0000_2100, 1'b0, 8'h0, 0, "R8 flushed");
        do_lookup(VECS[7].addr, 1'b0, 8'h0, 0, "R8 flushed table");

        // R8: lookup in the flush cycle answers miss
        do_fill(32'h0000_2120, 3, 8'hD1);
        @(negedge clk);
        flush = 1'b1; lk_valid = 1'b1; lk_addr = 32'h0000_2120;
        @(negedge clk);
        flush = 1'b0; lk_valid = 1'b0;
        chk(lk_resp == 1'b1 && lk_hit == 1'b0, "R8 lookup with flush",
            64'({lk_resp, lk_hit}), 64'b10);

        // R8: fill in the flush cycle is dropped
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_addr = 32'h0000_2140;
        fill_count = 6'd3; fill_uops = mk_uops(8'hD2, 3);
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        do_lookup(32'h0000_2140, 1'b0, 8'h0, 0, "R8 fill with flush");

        // R9: lookup and fill of one window in one cycle
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = 32'h0000_2160;
        fill_count = 6'd5; fill_uops = mk_uops(8'hE1, 5);
        lk_valid = 1'b1; lk_addr = 32'h0000_2160;
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        chk(lk_resp == 1'b1 && lk_hit == 1'b0, "R9 old contents seen",
            64'({lk_resp, lk_hit}), 64'b10);
        do_lookup(32'h0000_2160, 1'b1, 8'hE1, 5, "R9 filled after");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule